// File: doc/BRIEF.md
# Chip Test Mode Controller

This block chooses the chip-level test mode and applies it at the pads. Two active-low test pins are decoded together with a strap level that is latched from a dedicated pin while the system reset is held. With both test pins low, a latched strap of 1 turns on the processor debug logic. A latched strap of 0 instead takes every pad driver off the board, so that other parts can be tested in circuit. This override works without a clock and leaves all internal state untouched.

A separate software control bit (bit 11 of the system control word, brought in as one wire) turns on bus mirroring. While it is set, every internal peripheral-register access is shown on the external address and data pins as though it were an external access to chip-select 5. The same bit also takes over the low three port-E pins to carry the gated processor clock and the two interrupt request lines.

A mirrored access can meet a genuine external cycle. In that case the external cycle wins and the internal access is held off. A sticky flag records any such clash that happens while display DMA is running.

Top module: `tmc_top`

## Requirements
- R1: `dbg_en` is 1 exactly when `test_a_n`=0, `test_b_n`=0 and the latched strap is 1. It is 0 in every other case, including straight after reset with any test pin high.
- R2: When `test_a_n`=0, `test_b_n`=0 and the latched strap is 0, all pad enables are 0 in the same cycle. This covers `pad_addr_oe`, `pad_data_oe`, `pad_cs_oe` and every bit of `pad_pe_oe`. The override is combinational and needs no clock edge.
- R3: The strap is sampled from `strap_in` on every clock while `rst_n`=0. After `rst_n` rises it holds its value until the next reset, whatever `strap_in` does.
- R4: The high-impedance mode changes only the pad enables. Pad data values, the collision flag and the latched strap are the same during and after it as they would be without it.
- R5: With `mirror_on`=1, an internal access (`int_req`=1) that has no external request alongside it puts `int_addr` on `pad_addr` and drives `pad_cs_n[5]` low. It also drives `pad_data_oe`=1, with `pad_data` equal to `int_wdata` on writes (`int_we`=1) and to `int_rdata` on reads.
- R6: `pad_cs_n[i]` = 0 whenever `ext_req`=1 and `ext_cs[i]`=1, whether mirroring is on or off. Chip-select 5 is therefore shared by mirrored and genuine accesses.
- R7: With `mirror_on`=0, internal accesses leave the pads alone: `pad_addr`=`ext_addr`, `pad_cs_n` depends only on the external request, and `int_stall`=0.
- R8: With `mirror_on`=1 and both `int_req` and `ext_req` at 1, `int_stall`=1 and the pads carry the external cycle (address, data and chip-selects). Once `ext_req` falls, the held internal access is mirrored.
- R9: `dma_collision` goes to 1 on the clock edge after a cycle with `int_stall`=1 and `dma_active`=1. It then stays 1 until reset. A collision with `dma_active`=0 does not set it.
- R10: With `mirror_on`=1, `pad_pe[0]` = `cpu_clk_src` AND `cpu_run`, `pad_pe[1]` = `fiq_n` and `pad_pe[2]` = `irq_n`, and those three enables are 1.
- R11: Port-E bits 3 and up always follow `port_e_do`/`port_e_oe`. Bits 0 to 2 do the same when `mirror_on`=0.
- R12: Test pin combinations other than both-low select normal mode: `dbg_en`=0 and pad enables follow their functional values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| test_a_n | input | 1 | First active-low test-select pin |
| test_b_n | input | 1 | Second active-low test-select pin |
| strap_in | input | 1 | Strap level latched while reset is held |
| mirror_on | input | 1 | Software bit 11 of system control: mirroring and port takeover |
| int_req | input | 1 | Internal peripheral-register access in progress |
| int_we | input | 1 | Internal access is a write |
| int_addr | input | AW | Internal access address |
| int_wdata | input | DW | Internal write data |
| int_rdata | input | DW | Internal read data |
| ext_req | input | 1 | Genuine external-bus cycle pending |
| ext_we | input | 1 | External cycle is a write |
| ext_addr | input | AW | External cycle address |
| ext_wdata | input | DW | External write data |
| ext_cs | input | NCS | External chip-select decode, active high |
| dma_active | input | 1 | Display DMA is running |
| cpu_clk_src | input | 1 | Processor clock source |
| cpu_run | input | 1 | 1 when the processor is not waited |
| fiq_n | input | 1 | Fast interrupt request to processor |
| irq_n | input | 1 | Normal interrupt request to processor |
| port_e_do | input | PEW | Functional port-E output data |
| port_e_oe | input | PEW | Functional port-E output enables |
| pad_addr | output | AW | Address pad values |
| pad_addr_oe | output | 1 | Address pad enable |
| pad_data | output | DW | Data pad values |
| pad_data_oe | output | 1 | Data pad enable |
| pad_cs_n | output | NCS | Active-low chip-select pad values |
| pad_cs_oe | output | 1 | Chip-select pad enable |
| pad_pe | output | PEW | Port-E pad values |
| pad_pe_oe | output | PEW | Port-E pad enables |
| dbg_en | output | 1 | Processor debug logic enable |
| int_stall | output | 1 | Internal access held off by an external cycle |
| dma_collision | output | 1 | Sticky: a clash occurred during display DMA |

## Verification
Several rules are watched by assertions on every clock. Pad enables must be off whenever the high-impedance decode holds. Debug must never be enabled without both test pins low. The strap must hold after reset, and a clash must give external priority. The collision flag must stay set, and the port takeover must force its three enables. The bench scenarios cover what needs a sequence or a history. That includes the strap being captured as the last level seen during reset, the pads carrying their functional values untouched through a high-impedance interval, and a stalled internal access being mirrored once the external cycle ends. It also covers DMA-gating of the flag and the full chip-select and port-E patterns.

// File: rtl/tmc_pkg.sv
// Shared types for the test mode controller.
package tmc_pkg;
    typedef enum logic [1:0] {
        TMC_NORMAL = 2'd0,
        TMC_DEBUG  = 2'd1,
        TMC_HIZ    = 2'd2
    } tmc_mode_t;
endpackage

// File: rtl/tmc_strap_capture.sv
// Latches the strap pin while reset is held and keeps it afterwards.
// Assumes rst_n is synchronous to clk and held for at least one edge.
module tmc_strap_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic strap_q
);
    // Track the pin during reset; freeze once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strap_q <= strap_in;
    end

    // R3: strap is frozen outside reset.
    assert_strap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/tmc_mode_decode.sv
// Combinational decode of test pins and latched strap into a test mode.
// Assumes the strap is valid from the first clock of reset onward.
module tmc_mode_decode
    import tmc_pkg::*;
(
    input  logic      test_a_n,
    input  logic      test_b_n,
    input  logic      strap_q,
    output tmc_mode_t mode
);
    // Both pins low picks a test mode; the strap selects which one.
    always_comb begin
        if (!test_a_n && !test_b_n)
            mode = strap_q ? TMC_DEBUG : TMC_HIZ;
        else
            mode = TMC_NORMAL;
    end
endmodule

// File: rtl/tmc_bus_mirror.sv
// Arbitrates internal-access mirroring against genuine external cycles
// and builds the external bus pad values. External cycles always win.
// Assumes ext_req stays high for the whole external cycle.
module tmc_bus_mirror #(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int NCS       = 6,
    parameter int MIRROR_CS = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mirror_on,
    input  logic           int_req,
    input  logic           int_we,
    input  logic [AW-1:0]  int_addr,
    input  logic [DW-1:0]  int_wdata,
    input  logic [DW-1:0]  int_rdata,
    input  logic           ext_req,
    input  logic           ext_we,
    input  logic [AW-1:0]  ext_addr,
    input  logic [DW-1:0]  ext_wdata,
    input  logic [NCS-1:0] ext_cs,
    input  logic           dma_active,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_data,
    output logic           bus_data_en,
    output logic [NCS-1:0] bus_cs_n,
    output logic           int_stall,
    output logic           dma_collision
);
    logic mir_go;
    logic clash;

    // Decide whether an internal access is shown or held off.
    always_comb begin
        clash  = mirror_on && int_req && ext_req;
        mir_go = mirror_on && int_req && !ext_req;
    end

    assign int_stall = clash;

    // Select the source of the address and data pads.
    always_comb begin
        bus_addr    = mir_go ? int_addr : ext_addr;
        bus_data    = ext_wdata;
        bus_data_en = ext_req && ext_we;
        if (mir_go) begin
            bus_data    = int_we ? int_wdata : int_rdata;
            bus_data_en = 1'b1;
        end
    end

    // Chip-selects: external decode, plus the shared select for mirroring.
    for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
        if (gi == MIRROR_CS) begin : g_shared
            assign bus_cs_n[gi] = !((ext_req && ext_cs[gi]) || mir_go);
        end else begin : g_plain
            assign bus_cs_n[gi] = !(ext_req && ext_cs[gi]);
        end
    end

    // Sticky record of a clash seen while display DMA runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_collision <= 1'b0;
        else if (clash && dma_active)
            dma_collision <= 1'b1;
    end

    // R8: a clash keeps the external address on the pads.
    assert_ext_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && int_req && mirror_on) |-> (int_stall && bus_addr == ext_addr));
    // R9: the collision flag never clears outside reset.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_collision |=> dma_collision);
    // R7: no stall while mirroring is off.
    assert_no_stall_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mirror_on |-> !int_stall);
endmodule

// File: rtl/tmc_port_mux.sv
// Replaces the low three port-E pins with processor clock and interrupt
// observation while mirroring is on. Upper bits pass through.
// Assumes PEW >= 3.
module tmc_port_mux #(
    parameter int PEW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mirror_on,
    input  logic           cpu_clk_src,
    input  logic           cpu_run,
    input  logic           fiq_n,
    input  logic           irq_n,
    input  logic [PEW-1:0] port_e_do,
    input  logic [PEW-1:0] port_e_oe,
    output logic [PEW-1:0] pe_val,
    output logic [PEW-1:0] pe_en
);
    localparam int NTEST = 3;
    logic [NTEST-1:0] obs;

    // Observation signals: gated clock, fast and normal interrupt.
    always_comb obs = {irq_n, fiq_n, cpu_clk_src & cpu_run};

    for (genvar gi = 0; gi < PEW; gi++) begin : g_pe
        if (gi < NTEST) begin : g_test
            assign pe_val[gi] = mirror_on ? obs[gi] : port_e_do[gi];
            assign pe_en[gi]  = mirror_on | port_e_oe[gi];
        end else begin : g_pass
            assign pe_val[gi] = port_e_do[gi];
            assign pe_en[gi]  = port_e_oe[gi];
        end
    end

    // R10: takeover drives the three observation pins.
    assert_pe_takeover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_on |-> (pe_en[NTEST-1:0] == '1));
endmodule

// File: rtl/tmc_top.sv
// Chip test mode controller: mode decode, strap capture, bus mirroring,
// port-E takeover and the asynchronous pad-enable override.
// Assumes all pad enables of the chip's test-controlled pads pass here.
module tmc_top
    import tmc_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int NCS = 6,
    parameter int PEW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_a_n,
    input  logic           test_b_n,
    input  logic           strap_in,
    input  logic           mirror_on,
    input  logic           int_req,
    input  logic           int_we,
    input  logic [AW-1:0]  int_addr,
    input  logic [DW-1:0]  int_wdata,
    input  logic [DW-1:0]  int_rdata,
    input  logic           ext_req,
    input  logic           ext_we,
    input  logic [AW-1:0]  ext_addr,
    input  logic [DW-1:0]  ext_wdata,
    input  logic [NCS-1:0] ext_cs,
    input  logic           dma_active,
    input  logic           cpu_clk_src,
    input  logic           cpu_run,
    input  logic           fiq_n,
    input  logic           irq_n,
    input  logic [PEW-1:0] port_e_do,
    input  logic [PEW-1:0] port_e_oe,
    output logic [AW-1:0]  pad_addr,
    output logic           pad_addr_oe,
    output logic [DW-1:0]  pad_data,
    output logic           pad_data_oe,
    output logic [NCS-1:0] pad_cs_n,
    output logic           pad_cs_oe,
    output logic [PEW-1:0] pad_pe,
    output logic [PEW-1:0] pad_pe_oe,
    output logic           dbg_en,
    output logic           int_stall,
    output logic           dma_collision
);
    localparam int MIRROR_CS = 5;

    logic      strap_q;
    tmc_mode_t mode;
    logic      hiz;
    logic      data_en;
    logic [PEW-1:0] pe_en;

    tmc_strap_capture u_strap (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_q(strap_q)
    );

    tmc_mode_decode u_dec (
        .test_a_n(test_a_n), .test_b_n(test_b_n), .strap_q(strap_q), .mode(mode)
    );

    tmc_bus_mirror #(.AW(AW), .DW(DW), .NCS(NCS), .MIRROR_CS(MIRROR_CS)) u_mir (
        .clk(clk), .rst_n(rst_n), .mirror_on(mirror_on),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_cs(ext_cs), .dma_active(dma_active),
        .bus_addr(pad_addr), .bus_data(pad_data), .bus_data_en(data_en),
        .bus_cs_n(pad_cs_n), .int_stall(int_stall), .dma_collision(dma_collision)
    );

    tmc_port_mux #(.PEW(PEW)) u_pe (
        .clk(clk), .rst_n(rst_n), .mirror_on(mirror_on),
        .cpu_clk_src(cpu_clk_src), .cpu_run(cpu_run), .fiq_n(fiq_n), .irq_n(irq_n),
        .port_e_do(port_e_do), .port_e_oe(port_e_oe),
        .pe_val(pad_pe), .pe_en(pe_en)
    );

    // Mode flags derived from the decoded mode.
    always_comb begin
        hiz    = (mode == TMC_HIZ);
        dbg_en = (mode == TMC_DEBUG);
    end

    // Asynchronous override of every pad enable in high-impedance mode.
    always_comb begin
        pad_addr_oe = !hiz;
        pad_cs_oe   = !hiz;
        pad_data_oe = data_en && !hiz;
        pad_pe_oe   = hiz ? '0 : pe_en;
    end

    // R2: both test pins low with strap 0 leaves no enable on.
    assert_hiz_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_a_n && !test_b_n && !strap_q) |->
        (!pad_addr_oe && !pad_data_oe && !pad_cs_oe && pad_pe_oe == '0));
    // R1: debug is never enabled unless both test pins are low.
    assert_dbg_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_en |-> (!test_a_n && !test_b_n && strap_q));
    // R12: with a test pin high the address pads are driven.
    assert_normal_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (test_a_n || test_b_n) |-> (pad_addr_oe && pad_cs_oe && !dbg_en));
endmodule

// File: tb/tmc_top_bench.sv
module tmc_top_bench;
    localparam int CLK_P = 10;
    localparam int AW = 16, DW = 32, NCS = 6, PEW = 8;

    logic clk = 0;
    logic rst_n, test_a_n, test_b_n, strap_in, mirror_on;
    logic int_req, int_we, ext_req, ext_we, dma_active;
    logic [AW-1:0] int_addr, ext_addr;
    logic [DW-1:0] int_wdata, int_rdata, ext_wdata;
    logic [NCS-1:0] ext_cs;
    logic cpu_clk_src, cpu_run, fiq_n, irq_n;
    logic [PEW-1:0] port_e_do, port_e_oe;
    logic [AW-1:0] pad_addr;
    logic [DW-1:0] pad_data;
    logic [NCS-1:0] pad_cs_n;
    logic [PEW-1:0] pad_pe, pad_pe_oe;
    logic pad_addr_oe, pad_data_oe, pad_cs_oe, dbg_en, int_stall, dma_collision;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tmc_top #(.AW(AW), .DW(DW), .NCS(NCS), .PEW(PEW)) u_tmc_top (.*);

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mirror_on = 0; int_req = 0; int_we = 0; ext_req = 0; ext_we = 0;
        dma_active = 0; int_addr = 16'h1111; ext_addr = 16'h2222;
        int_wdata = 32'hA0A0_0001; int_rdata = 32'hB0B0_0002; ext_wdata = 32'hC0C0_0003;
        ext_cs = '0; cpu_clk_src = 1; cpu_run = 1; fiq_n = 1; irq_n = 1;
        port_e_do = 8'h5A; port_e_oe = 8'hF0;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 0; strap_in = ~strap;
        @(negedge clk);
        strap_in = strap;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        test_a_n = 1; test_b_n = 1; idle_inputs();
        do_reset(1);
        #1;
        chk(dbg_en, 0, "R1 reset debug off");
        chk(dma_collision, 0, "R9 reset flag clear");
        chk({pad_addr_oe, pad_cs_oe, pad_data_oe}, 3'b110, "R12 reset enables");
        chk(pad_cs_n, 6'h3F, "R6 reset cs idle");
    endtask

    task automatic t_debug();
        do_reset(1);
        strap_in = 0;
        @(negedge clk);
        test_a_n = 0; test_b_n = 0; #1;
        chk(dbg_en, 1, "R1 debug on (strap held as 1, R3)");
        chk(pad_addr_oe, 1, "R1 debug keeps pads driven");
        test_b_n = 1; #1;
        chk(dbg_en, 0, "R12 one pin high debug off");
        test_a_n = 1; test_b_n = 0; #1;
        chk(dbg_en, 0, "R12 other pin high debug off");
        test_a_n = 1; test_b_n = 1;
    endtask

    task automatic t_mirror();
        @(negedge clk);
        mirror_on = 1; int_req = 1; int_we = 1; #1;
        chk(pad_addr, 16'h1111, "R5 mirrored address");
        chk(pad_cs_n, 6'h1F, "R5 cs5 low for mirror");
        chk({pad_data_oe, pad_data}, {1'b1, 32'hA0A0_0001}, "R5 write data");
        int_we = 0; #1;
        chk({pad_data_oe, pad_data}, {1'b1, 32'hB0B0_0002}, "R5 read data");
        int_req = 0; ext_req = 1; ext_we = 0; ext_cs = 6'h20; #1;
        chk(pad_cs_n, 6'h1F, "R6 cs5 for genuine access");
        chk(pad_data_oe, 0, "R6 external read no data drive");
        ext_cs = 6'h04; #1;
        chk(pad_cs_n, 6'h3B, "R6 cs2 genuine");
        ext_req = 0; ext_cs = 0; mirror_on = 0;
    endtask

    task automatic t_mirror_off();
        @(negedge clk);
        mirror_on = 0; int_req = 1; int_we = 1; #1;
        chk(pad_addr, 16'h2222, "R7 address not mirrored");
        chk(pad_cs_n, 6'h3F, "R7 no cs");
        chk({pad_data_oe, int_stall}, 2'b00, "R7 no data, no stall");
        ext_req = 1; ext_cs = 6'h20; #1;
        chk(pad_cs_n, 6'h1F, "R6 cs5 with mirroring off");
        chk(int_stall, 0, "R7 no stall off");
        int_req = 0; ext_req = 0; ext_cs = 0;
    endtask

    task automatic t_collision();
        @(negedge clk);
        mirror_on = 1; int_req = 1; int_we = 1;
        ext_req = 1; ext_we = 1; ext_cs = 6'h01; dma_active = 0; #1;
        chk(int_stall, 1, "R8 stall on clash");
        chk(pad_addr, 16'h2222, "R8 external address wins");
        chk({pad_cs_n, pad_data}, {6'h3E, 32'hC0C0_0003}, "R8 external cs and data");
        @(negedge clk); #1;
        chk(dma_collision, 0, "R9 no flag without DMA");
        ext_req = 0; #1;
        chk({int_stall, pad_addr}, {1'b0, 16'h1111}, "R8 held access mirrored after");
        ext_req = 1; dma_active = 1;
        @(negedge clk); #1;
        chk(dma_collision, 1, "R9 flag set on DMA clash");
        ext_req = 0; int_req = 0; dma_active = 0;
        @(negedge clk); @(negedge clk); #1;
        chk(dma_collision, 1, "R9 flag sticky");
        mirror_on = 0; ext_cs = 0; ext_we = 0;
    endtask

    task automatic t_port();
        @(negedge clk);
        mirror_on = 1; cpu_clk_src = 1; cpu_run = 0; fiq_n = 0; irq_n = 1; #1;
        chk(pad_pe, 8'h5C, "R10 clock gated low, fiq low, irq high");
        chk(pad_pe_oe, 8'hF7, "R10 forced enables");
        cpu_run = 1; fiq_n = 1; irq_n = 0; #1;
        chk(pad_pe, 8'h5B, "R10 clock high, irq low");
        mirror_on = 0; #1;
        chk({pad_pe, pad_pe_oe}, {8'h5A, 8'hF0}, "R11 port normal");
        port_e_do = 8'hA5; port_e_oe = 8'h0F; mirror_on = 1; #1;
        chk(pad_pe[7:3], 5'h14, "R11 upper bits pass");
        chk(pad_pe_oe[7:3], 5'h01, "R11 upper enables pass");
        mirror_on = 0; port_e_do = 8'h5A; port_e_oe = 8'hF0;
    endtask

    task automatic t_hiz();
        do_reset(0);
        strap_in = 1;
        @(negedge clk);
        mirror_on = 1; int_req = 1; ext_req = 1; ext_cs = 6'h01; dma_active = 1;
        @(negedge clk);
        ext_req = 0; ext_cs = 0; dma_active = 0; #1;
        chk(dma_collision, 1, "R4 flag set before hiz");
        @(negedge clk);
        test_a_n = 0; test_b_n = 0; #1;
        chk({pad_addr_oe, pad_data_oe, pad_cs_oe}, 3'b000, "R2 bus enables off");
        chk(pad_pe_oe, 8'h00, "R2 port enables off");
        chk(dbg_en, 0, "R1 no debug with strap 0 (R3 held)");
        chk({pad_addr, pad_cs_n}, {16'h1111, 6'h1F}, "R4 pad values unchanged");
        chk(pad_pe[0], 1, "R4 port value unchanged");
        repeat (3) @(negedge clk);
        test_a_n = 1; #1;
        chk(dma_collision, 1, "R4 flag kept through hiz");
        chk({pad_addr_oe, pad_data_oe, pad_cs_oe}, 3'b111, "R4 enables return");
        chk(pad_pe_oe, 8'hF7, "R4 port enables return");
        mirror_on = 0; int_req = 0; test_b_n = 1;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; strap_in = 1;
        t_reset();
        t_debug();
        t_mirror();
        t_mirror_off();
        t_collision();
        t_port();
        t_hiz();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule